// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits on the display-control write port of a video controller. Every write is a 32-bit word whose top byte picks a command and whose lower bits carry that command's argument. The decoder keeps the display state those commands set: the status word, the start position of the shown image in frame memory, the horizontal and vertical display windows, and the display mode. From that state it works out the active horizontal and vertical resolution and the visible picture width.

The visible width is the horizontal window length scaled against a 2560-unit span and multiplied by the active horizontal resolution. A small shift-subtract divider computes it over several cycles and raises a valid flag when the result is ready. Commands in a dedicated query range do not touch the display state. Instead, they load a readback register with one of six externally held 20-bit parameter words.

Top module: `disp_ctl_top`

## Requirements
- R1: The command number is `wr_data[31:24]`. Commands 0x00–0x0F each keep the last word accepted for them. Apart from commands 0x00 and 0x05, a write whose full 32-bit word equals the kept word is dropped: it changes nothing and does not restart the width computation, so `width_valid` stays high.
- R2: Command 0x00, and also synchronous reset, does the following. It sets `status` to 0x14802000. It clears every kept word, the display start and both display windows. It does not alter `readback`, which only reset clears to 0.
- R3: Command 0x03 copies `wr_data[0]` into `status[23]` (blanking).
- R4: Command 0x04 copies `wr_data[1:0]` into `status[30:29]` (transfer direction).
- R5: Command 0x05 sets `disp_x` from `wr_data[9:0]` and `disp_y` from `wr_data[19:10]`.
- R6: Command 0x06 sets the horizontal window: start from `wr_data[11:0]`, end from `wr_data[23:12]`. Command 0x07 sets the vertical window: start from `wr_data[9:0]`, end from `wr_data[19:10]`. The vertical window appears on `vstart` and `vend`.
- R7: Command 0x08 rewrites `status[22:16]`. `wr_data[5:0]` goes to `status[22:17]` and `wr_data[6]` goes to `status[16]`.
- R8: `hres` is looked up with `status[18:16]` = 0..7 in the table 256, 368, 320, 384, 512, 512, 640, 640. `vres` is looked up with `status[20:19]` = 0..3 in the table 240, 480, 256, 480.
- R9: Let d = horizontal end − horizontal start. When 1 ≤ d ≤ 2559, `width` = floor(d·hres/2560). Otherwise `width` = `hres`.
- R10: The following change at the clock edge that accepts a write: `status`, `disp_x`, `disp_y`, the windows, `hres`, `vres` and `readback`. An accepted command 0x00, 0x06 or 0x08 clears `width_valid` at that edge. In the out-of-range case the new `width` and `width_valid`=1 appear one edge later; otherwise they appear eleven edges later. A further accepted 0x00/0x06/0x08 restarts the computation. The same one-edge path runs after reset.
- R11: Commands 0x10–0x1F are queries with selector `wr_data[3:0]`. Selector k = 2..7 loads `readback` with external word k, zero-extended. Selector 8 loads external word 5. Other selectors leave `readback` unchanged. External word k is `ext_regs[20(k−2)+19 : 20(k−2)]`.
- R12: Commands 0x20–0xFF have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Command byte and argument |
| ext_regs | input | 120 | Six 20-bit external parameter words (numbers 2..7) |
| status | output | 32 | Status word |
| readback | output | 32 | Query result register |
| disp_x | output | 10 | Display start X |
| disp_y | output | 10 | Display start Y |
| vstart | output | 10 | Vertical window start |
| vend | output | 10 | Vertical window end |
| hres | output | 10 | Active horizontal resolution |
| vres | output | 9 | Active vertical resolution |
| width | output | 10 | Visible picture width |
| width_valid | output | 1 | Width result is current |

## Verification
The bound checker watches several things on every cycle. It checks how the blanking, direction, start and mode fields follow a write one edge later. It checks that a reset command restores the status word and drops the width flag. It checks that resolutions stay inside their tables and that a valid width never exceeds `hres`. It also checks that the width holds while no write arrives, and that state commands and out-of-range commands leave `readback` or the status alone. The bench's scenarios are needed for the rest: the exact divided width and its eleven-edge latency, the dropping of repeated words (seen only through an undisturbed `width_valid`), a restart in mid-computation, and the selector-to-word mapping of queries.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int CMD_W    = 8;
    localparam int NREG     = 16;
    localparam int IDX_W    = $clog2(NREG);
    localparam int HPOS_W   = 12;
    localparam int VPOS_W   = 10;
    localparam int START_W  = 10;
    localparam int HRES_W   = 10;
    localparam int VRES_W   = 9;
    localparam int SPAN     = 2560;
    localparam int EXT_LO   = 2;
    localparam int EXT_HI   = 7;
    localparam int EXT_N    = EXT_HI - EXT_LO + 1;
    localparam int EXT_W    = 20;
    localparam int SEL_W    = 4;

    localparam logic [DATA_W-1:0] STATUS_RST = 32'h1480_2000;

    localparam int BLANK_BIT = 23;
    localparam int DIR_LO    = 29;
    localparam int DIR_HI    = 30;
    localparam int MODE_LO   = 16;
    localparam int MODE_HI   = 22;
    localparam int HSEL_LO   = 16;
    localparam int VSEL_LO   = 19;

    localparam logic [CMD_W-1:0] CMD_RESET  = 8'h00;
    localparam logic [CMD_W-1:0] CMD_BLANK  = 8'h03;
    localparam logic [CMD_W-1:0] CMD_DIR    = 8'h04;
    localparam logic [CMD_W-1:0] CMD_START  = 8'h05;
    localparam logic [CMD_W-1:0] CMD_HWIN   = 8'h06;
    localparam logic [CMD_W-1:0] CMD_VWIN   = 8'h07;
    localparam logic [CMD_W-1:0] CMD_MODE   = 8'h08;
    localparam logic [CMD_W-1:0] CMD_QUERY  = 8'h10;
    localparam logic [SEL_W-1:0] SEL_ALIAS  = 4'h8;
    localparam int               ALIAS_IDX  = 5;

    typedef struct packed {
        logic [CMD_W-1:0]        cmd;
        logic [DATA_W-CMD_W-1:0] arg;
    } wr_word_t;

    typedef struct packed {
        logic [START_W-1:0] sx;
        logic [START_W-1:0] sy;
        logic [HPOS_W-1:0]  hs;
        logic [HPOS_W-1:0]  he;
        logic [VPOS_W-1:0]  vs;
        logic [VPOS_W-1:0]  ve;
    } geom_t;

    typedef enum logic [1:0] {
        DIV_IDLE,
        DIV_LOAD,
        DIV_RUN
    } div_state_e;

    function automatic logic [HRES_W-1:0] hres_lut(input logic [2:0] code);
        case (code)
            3'd0:        return HRES_W'(256);
            3'd1:        return HRES_W'(368);
            3'd2:        return HRES_W'(320);
            3'd3:        return HRES_W'(384);
            3'd4, 3'd5:  return HRES_W'(512);
            default:     return HRES_W'(640);
        endcase
    endfunction

    function automatic logic [VRES_W-1:0] vres_lut(input logic [1:0] code);
        case (code)
            2'd0:    return VRES_W'(240);
            2'd2:    return VRES_W'(256);
            default: return VRES_W'(480);
        endcase
    endfunction

endpackage

// File: rtl/disp_ctl_regs.sv
module disp_ctl_regs
    import disp_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status,
    output geom_t             geom,
    output logic              recalc
);

    logic [DATA_W-1:0] kept [NREG];
    wr_word_t          w;
    logic [IDX_W-1:0]  idx;
    logic              in_file;
    logic              repeat_word;
    logic              exempt;
    logic              accept;

    assign w           = wr_data;
    assign idx         = w.cmd[IDX_W-1:0];
    assign in_file     = (w.cmd[CMD_W-1:IDX_W] == '0);
    assign repeat_word = (kept[idx] == wr_data);
    assign exempt      = (w.cmd == CMD_RESET) || (w.cmd == CMD_START);
    assign accept      = wr_en && in_file && (exempt || !repeat_word);

    // restart the width path whenever its inputs may have moved
    assign recalc = accept &&
                    ((w.cmd == CMD_RESET) || (w.cmd == CMD_HWIN) || (w.cmd == CMD_MODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                kept[i] <= '0;
            end
            status <= STATUS_RST;
            geom   <= '0;
        end else if (accept) begin
            if (w.cmd == CMD_RESET) begin
                for (int i = 0; i < NREG; i++) begin
                    kept[i] <= '0;
                end
                status <= STATUS_RST;
                geom   <= '0;
            end else begin
                kept[idx] <= wr_data;
                case (w.cmd)
                    CMD_BLANK: status[BLANK_BIT] <= w.arg[0];
                    CMD_DIR:   status[DIR_HI:DIR_LO] <= w.arg[1:0];
                    CMD_START: begin
                        geom.sx <= w.arg[START_W-1:0];
                        geom.sy <= w.arg[2*START_W-1:START_W];
                    end
                    CMD_HWIN: begin
                        geom.hs <= w.arg[HPOS_W-1:0];
                        geom.he <= w.arg[2*HPOS_W-1:HPOS_W];
                    end
                    CMD_VWIN: begin
                        geom.vs <= w.arg[VPOS_W-1:0];
                        geom.ve <= w.arg[2*VPOS_W-1:VPOS_W];
                    end
                    CMD_MODE:  status[MODE_HI:MODE_LO] <= {w.arg[5:0], w.arg[6]};
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/disp_ctl_mode_lut.sv
module disp_ctl_mode_lut
    import disp_ctl_pkg::*;
(
    input  logic [2:0]        hsel,
    input  logic [1:0]        vsel,
    output logic [HRES_W-1:0] hres,
    output logic [VRES_W-1:0] vres
);

    always_comb begin
        hres = hres_lut(hsel);
        vres = vres_lut(vsel);
    end

endmodule

// File: rtl/disp_ctl_width_div.sv
module disp_ctl_width_div
    import disp_ctl_pkg::*;
#(
    parameter int POS_W  = HPOS_W,
    parameter int RES_W  = HRES_W,
    parameter int DIVSOR = SPAN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [POS_W-1:0] h_lo,
    input  logic [POS_W-1:0] h_hi,
    input  logic [RES_W-1:0] res,
    output logic [RES_W-1:0] width,
    output logic             done
);

    localparam int QW = RES_W;
    localparam int PW = POS_W + RES_W;
    localparam int CW = $clog2(QW);

    div_state_e      st;
    logic [POS_W:0]  diff;
    logic            in_span;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   rem;
    logic [PW-1:0]   dsh;
    logic [QW-1:0]   q;
    logic [QW-1:0]   q_nx;
    logic [CW-1:0]   cnt;
    logic            take;

    assign diff    = {1'b0, h_hi} - {1'b0, h_lo};
    assign in_span = !diff[POS_W] && (diff != '0) && (diff < (POS_W+1)'(DIVSOR));
    assign prod    = PW'(diff[POS_W-1:0]) * PW'(res);
    assign dsh     = PW'(DIVSOR) << cnt;
    assign take    = (rem >= dsh);

    always_comb begin
        q_nx      = q;
        q_nx[cnt] = take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= DIV_LOAD;
            done  <= 1'b0;
            width <= '0;
            rem   <= '0;
            q     <= '0;
            cnt   <= '0;
        end else if (start) begin
            st   <= DIV_LOAD;
            done <= 1'b0;
        end else begin
            case (st)
                DIV_LOAD: begin
                    if (!in_span) begin
                        width <= res;
                        done  <= 1'b1;
                        st    <= DIV_IDLE;
                    end else begin
                        rem <= prod;
                        q   <= '0;
                        cnt <= CW'(QW - 1);
                        st  <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    if (take) begin
                        rem <= rem - dsh;
                    end
                    q <= q_nx;
                    if (cnt == '0) begin
                        width <= q_nx;
                        done  <= 1'b1;
                        st    <= DIV_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/disp_ctl_query.sv
module disp_ctl_query
    import disp_ctl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [CMD_W-1:0]       cmd,
    input  logic [SEL_W-1:0]       sel,
    input  logic [EXT_N*EXT_W-1:0] ext_regs,
    output logic [DATA_W-1:0]      readback
);

    logic [EXT_W-1:0] word [EXT_N];
    logic             is_query;
    logic             hit;
    logic [EXT_W-1:0] pick;

    for (genvar k = 0; k < EXT_N; k++) begin : g_unpack
        assign word[k] = ext_regs[k*EXT_W +: EXT_W];
    end

    assign is_query = (cmd[CMD_W-1:SEL_W] == CMD_QUERY[CMD_W-1:SEL_W]);

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 0; k < EXT_N; k++) begin
            if (sel == SEL_W'(k + EXT_LO)) begin
                hit  = 1'b1;
                pick = word[k];
            end
        end
        if (sel == SEL_ALIAS) begin
            hit  = 1'b1;
            pick = word[ALIAS_IDX - EXT_LO];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            readback <= '0;
        end else if (wr_en && is_query && hit) begin
            readback <= DATA_W'(pick);
        end
    end

endmodule

// File: rtl/disp_ctl_top.sv
module disp_ctl_top
    import disp_ctl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [EXT_N*EXT_W-1:0] ext_regs,
    output logic [DATA_W-1:0]      status,
    output logic [DATA_W-1:0]      readback,
    output logic [START_W-1:0]     disp_x,
    output logic [START_W-1:0]     disp_y,
    output logic [VPOS_W-1:0]      vstart,
    output logic [VPOS_W-1:0]      vend,
    output logic [HRES_W-1:0]      hres,
    output logic [VRES_W-1:0]      vres,
    output logic [HRES_W-1:0]      width,
    output logic                   width_valid
);

    geom_t geom;
    logic  recalc;

    disp_ctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .status  (status),
        .geom    (geom),
        .recalc  (recalc)
    );

    disp_ctl_mode_lut u_lut (
        .hsel (status[HSEL_LO+2:HSEL_LO]),
        .vsel (status[VSEL_LO+1:VSEL_LO]),
        .hres (hres),
        .vres (vres)
    );

    disp_ctl_width_div #(
        .POS_W  (HPOS_W),
        .RES_W  (HRES_W),
        .DIVSOR (SPAN)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (recalc),
        .h_lo  (geom.hs),
        .h_hi  (geom.he),
        .res   (hres),
        .width (width),
        .done  (width_valid)
    );

    disp_ctl_query u_query (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .cmd      (wr_data[DATA_W-1:DATA_W-CMD_W]),
        .sel      (wr_data[SEL_W-1:0]),
        .ext_regs (ext_regs),
        .readback (readback)
    );

    assign disp_x = geom.sx;
    assign disp_y = geom.sy;
    assign vstart = geom.vs;
    assign vend   = geom.ve;

endmodule

// File: rtl/disp_ctl_chk.sv
module disp_ctl_chk
    import disp_ctl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [CMD_W-1:0]    wr_cmd,
    input logic [19:0]         wr_arg,
    input logic [DATA_W-1:0]   status,
    input logic [DATA_W-1:0]   readback,
    input logic [START_W-1:0]  disp_x,
    input logic [START_W-1:0]  disp_y,
    input logic [HRES_W-1:0]   hres,
    input logic [VRES_W-1:0]   vres,
    input logic [HRES_W-1:0]   width,
    input logic                width_valid
);

    // R2
    rst_status_chk: assert property (@(posedge clk) rst |=> status == STATUS_RST);

    // R2
    cmd_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd == CMD_RESET) |=>
            (status == STATUS_RST && disp_x == '0 && disp_y == '0 && !width_valid));

    // R3
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd == CMD_BLANK) |=> status[BLANK_BIT] == $past(wr_arg[0]));

    // R4
    dir_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd == CMD_DIR) |=> status[DIR_HI:DIR_LO] == $past(wr_arg[1:0]));

    // R5
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd == CMD_START) |=>
            (disp_x == $past(wr_arg[9:0]) && disp_y == $past(wr_arg[19:10])));

    // R7
    mode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd == CMD_MODE) |=>
            status[MODE_HI:MODE_LO] == {$past(wr_arg[5:0]), $past(wr_arg[6])});

    // R8
    hres_set_chk: assert property (@(posedge clk) disable iff (rst)
        hres inside {10'd256, 10'd320, 10'd368, 10'd384, 10'd512, 10'd640});

    // R8
    vres_set_chk: assert property (@(posedge clk) disable iff (rst)
        vres inside {9'd240, 9'd256, 9'd480});

    // R9
    width_bound_chk: assert property (@(posedge clk) disable iff (rst)
        width_valid |-> width <= hres);

    // R10
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (width_valid && !wr_en) |=> (width_valid && $stable(width)));

    // R11
    rb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd < 8'h10) |=> $stable(readback));

    // R12
    high_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd >= 8'h20) |=> ($stable(status) && $stable(readback)));

endmodule

bind disp_ctl_top disp_ctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_cmd      (wr_data[31:24]),
    .wr_arg      (wr_data[19:0]),
    .status      (status),
    .readback    (readback),
    .disp_x      (disp_x),
    .disp_y      (disp_y),
    .hres        (hres),
    .vres        (vres),
    .width       (width),
    .width_valid (width_valid)
);

// File: tb/disp_ctl_top_tb.sv
module disp_ctl_top_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [119:0] ext_regs;
    logic [31:0]  status, readback;
    logic [9:0]   disp_x, disp_y, vstart, vend, hres, width;
    logic [8:0]   vres;
    logic         width_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_run = 0;

    disp_ctl_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ext_regs(ext_regs),
        .status(status), .readback(readback), .disp_x(disp_x), .disp_y(disp_y),
        .vstart(vstart), .vend(vend), .hres(hres), .vres(vres),
        .width(width), .width_valid(width_valid)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    logic [31:0] m_kept [16];
    logic [31:0] m_status, m_rb;
    int m_sx, m_sy, m_hs, m_he, m_vs, m_ve;
    int m_width, m_target, m_cnt;

    function automatic int hres_of(logic [31:0] s);
        case ((s >> 16) & 7)
            0: return 256;
            1: return 368;
            2: return 320;
            3: return 384;
            4: return 512;
            5: return 512;
            default: return 640;
        endcase
    endfunction

    function automatic int vres_of(logic [31:0] s);
        case ((s >> 19) & 3)
            0: return 240;
            2: return 256;
            default: return 480;
        endcase
    endfunction

    function automatic int ext_word(int k);
        return int'(ext_regs[(k-2)*20 +: 20]);
    endfunction

    task automatic arm_width();
        int d, h;
        d = m_he - m_hs;
        h = hres_of(m_status);
        if (d <= 0 || d >= 2560) begin
            m_target = h;
            m_cnt = 1;
        end else begin
            m_target = d * h / 2560;
            m_cnt = 11;
        end
    endtask

    task automatic clear_state();
        for (int i = 0; i < 16; i++) m_kept[i] = '0;
        m_status = 32'h1480_2000;
        m_sx = 0; m_sy = 0; m_hs = 0; m_he = 0; m_vs = 0; m_ve = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            clear_state();
            m_rb = '0;
            m_width = 0;
            m_target = 256;
            m_cnt = 1;
        end else begin
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) m_width = m_target;
            end
            if (wr_en) begin
                int cmd;
                int sel;
                cmd = int'(wr_data[31:24]);
                sel = int'(wr_data[3:0]);
                if (cmd < 16) begin
                    if (cmd == 0 || cmd == 5 || m_kept[cmd] != wr_data) begin
                        m_kept[cmd] = wr_data;
                        case (cmd)
                            0: begin clear_state(); arm_width(); end
                            3: m_status[23] = wr_data[0];
                            4: m_status[30:29] = wr_data[1:0];
                            5: begin m_sx = wr_data & 32'h3ff; m_sy = (wr_data >> 10) & 32'h3ff; end
                            6: begin m_hs = wr_data & 32'hfff; m_he = (wr_data >> 12) & 32'hfff; arm_width(); end
                            7: begin m_vs = wr_data & 32'h3ff; m_ve = (wr_data >> 10) & 32'h3ff; end
                            8: begin
                                m_status = (m_status & ~32'h007f_0000)
                                         | ((wr_data & 32'h3f) << 17)
                                         | (((wr_data >> 6) & 1) << 16);
                                arm_width();
                            end
                            default: ;
                        endcase
                    end
                end else if (cmd < 32) begin
                    if (sel >= 2 && sel <= 7) m_rb = ext_word(sel);
                    else if (sel == 8) m_rb = ext_word(5);
                end
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic check(bit ok, string what, int got, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got %0h expected %0h (cycle %0d)", what, got, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        #2;
        cycles++;
        if (!rst) begin
            check(status == m_status, "R2/R3/R4/R7/R12 status", int'(status), int'(m_status));
            check(readback == m_rb, "R11/R2/R12 readback", int'(readback), int'(m_rb));
            check(int'(disp_x) == m_sx && int'(disp_y) == m_sy, "R5 start",
                  int'({disp_y, disp_x}), (m_sy << 10) | m_sx);
            check(int'(vstart) == m_vs && int'(vend) == m_ve, "R6 vertical window",
                  int'({vend, vstart}), (m_ve << 10) | m_vs);
            check(int'(hres) == hres_of(m_status) && int'(vres) == vres_of(m_status),
                  "R8 resolution", int'({vres, hres}), (vres_of(m_status) << 10) | hres_of(m_status));
            check(width_valid == (m_cnt == 0), "R1/R10 width_valid",
                  int'(width_valid), int'(m_cnt == 0));
            if (m_cnt == 0)
                check(int'(width) == m_width, "R9/R6 width", int'(width), m_width);
        end
        if (cycles > 60000 && !done_run) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] hwin(int s, int e);
        return 32'h0600_0000 | ((e & 32'hfff) << 12) | (s & 32'hfff);
    endfunction

    initial begin
        for (int k = 0; k < 6; k++)
            ext_regs[k*20 +: 20] = 20'(32'h9_1000 + k * 32'h1357);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(4);
        // R3, R4
        wr(32'h0300_0001); wr(32'h0300_0000); wr(32'h0400_0002); wr(32'h0400_0003);
        // R5: repeated start writes still taken
        wr(32'h0500_0000 | (200 << 10) | 100); wr(32'h0500_0000 | (200 << 10) | 100);
        // R6: vertical window
        wr(32'h0700_0000 | (300 << 10) | 16);
        // R9: boundary spans
        wr(hwin(608, 3168)); idle(4);
        wr(hwin(500, 1780)); idle(14);
        // R1: identical word dropped, valid stays high
        wr(hwin(500, 1780)); idle(4);
        wr(hwin(900, 100)); idle(4);
        wr(hwin(10, 11)); idle(14);
        wr(hwin(0, 2559)); idle(14);
        // R7, R8: every mode value
        for (int m = 0; m < 128; m++) begin
            wr(32'h0800_0000 | m);
            idle(12);
        end
        // R10: restart in mid computation
        wr(hwin(100, 1700)); idle(4);
        wr(32'h0800_0003); idle(14);
        // R11: all selectors
        for (int s = 0; s < 16; s++) begin
            wr(32'h1000_0000 | s);
            idle(1);
        end
        wr(32'h1F00_0008); idle(1);
        // R12: high commands
        wr(32'h2000_0001); wr(32'hFF12_3456); wr(32'h1300_0000); idle(2);
        // other stored commands
        wr(32'h0100_0000); wr(32'h0900_00ff); wr(32'h0F00_0001); idle(2);
        // R2: reset command during a divide
        wr(hwin(200, 1400)); idle(3);
        wr(32'h0000_0000); idle(4);
        wr(32'h0300_0000); idle(2);
        // R2: port reset
        @(negedge clk); rst = 1'b1;
        idle(2); rst = 1'b0;
        idle(5);
        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule